// File: doc/BRIEF.md
# Dual-Rank Bus Register with Serial Shift

This block holds two registers of equal width. The bus rank sits on a shared bidirectional data bus. The shift rank can move its contents serially, one bit per clock. The bus is split into a bus-in vector, a bus-out vector and an output-enable flag, so that a pad ring or an on-chip mux can merge them. Data moves between the two ranks in parallel, in either direction. This lets a word be captured from the bus, serialised out while a new word is loaded, or collected serially and then put back on the bus.

All state changes on the rising clock edge. The controls are active low and are sampled only at that edge. Exactly one operation takes effect per clock, chosen by fixed priority. Turning the bus drivers off never stops an operation. Wider words are built by tying one instance's serial output to the next instance's serial input.

Top module: `dual_rank_shreg`

## Requirements
- R1: Asserting rst_ni low zeroes both ranks at once, so bus_o and ser_o read 0 while reset is held.
- R2: When up_ni and down_ni are both low at a clock edge, both ranks become zero, whatever the other controls are.
- R3: When load_ni is low, and R2 does not apply, the bus rank takes bus_i at the edge and the shift rank holds.
- R4: When up_ni is low and load_ni is high, and R2 does not apply, the bus rank takes the shift rank's value and the shift rank holds.
- R5: When down_ni is low, load_ni is high and up_ni is high, the shift rank takes the bus rank's value and the bus rank holds.
- R6: When shift_ni is low and load_ni, up_ni and down_ni are all high, the shift rank moves one place toward bit 7 and ser_i enters bit 0. The bus rank holds. ser_o always equals the registered bit 7 of the shift rank.
- R7: Priority is clear, then load, then transfer up, then transfer down, then shift. Only the winning operation changes state.
- R8: With all controls high, both ranks hold their values.
- R9: bus_o always shows the bus rank. bus_oe_o is 1 only when drive_ni is low and load_ni is high, so a load turns the drivers off. The value of drive_ni never changes what the ranks do.
- R10: Two instances chained through ser_o to ser_i act as one shift rank of twice the width. After WIDTH shifts, the upper instance holds the lower instance's former shift rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | WIDTH | Bus value sampled on a load |
| bus_o | output | WIDTH | Bus rank contents |
| bus_oe_o | output | 1 | Bus driver enable |
| ser_i | input | 1 | Serial input into shift rank bit 0 |
| ser_o | output | 1 | Registered shift rank bit WIDTH-1 |
| load_ni | input | 1 | Bus load request, active low |
| drive_ni | input | 1 | Bus drive request, active low |
| up_ni | input | 1 | Shift-to-bus transfer request, active low |
| down_ni | input | 1 | Bus-to-shift transfer request, active low |
| shift_ni | input | 1 | Shift request, active low |

## Verification
A reference model in the bench is driven with single requests and with overlapping requests. Load with shift, down with shift, and clear with load each separate the priority order from a design that applies several operations at once. An asymmetric serial pattern of ones and zeros shows the shift direction and the entry bit. A transfer up then exposes the whole shift rank on the bus. Drive requests made together with loads, and separately from them, separate input dominance from plain output gating. A chained pair shows that a word crosses the instance boundary intact.

// File: rtl/dual_rank_pkg.sv
package dual_rank_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_LOAD  = 3'd2,
    OP_UP    = 3'd3,
    OP_DOWN  = 3'd4,
    OP_SHIFT = 3'd5
  } op_e;
endpackage

// File: rtl/dr_op_decode.sv
module dr_op_decode
  import dual_rank_pkg::*;
(
  input  logic load_ni,
  input  logic drive_ni,
  input  logic up_ni,
  input  logic down_ni,
  input  logic shift_ni,
  output op_e  op_o,
  output logic oe_o
);
  always_comb begin
    if (!up_ni && !down_ni) op_o = OP_CLEAR;
    else if (!load_ni)      op_o = OP_LOAD;
    else if (!up_ni)        op_o = OP_UP;
    else if (!down_ni)      op_o = OP_DOWN;
    else if (!shift_ni)     op_o = OP_SHIFT;
    else                    op_o = OP_HOLD;
  end

  // input side dominates the drivers
  assign oe_o = !drive_ni && load_ni;

  always_comb begin
    assert (!(oe_o && !load_ni)) else $error("p_load_blocks_oe_r9");
  end
endmodule

// File: rtl/dr_rank_a.sv
module dr_rank_a
  import dual_rank_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  op_e              op_i,
  input  logic [WIDTH-1:0] bus_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] a_o
);
  logic [WIDTH-1:0] a_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) a_q <= '0;
    else begin
      case (op_i)
        OP_CLEAR: a_q <= '0;
        OP_LOAD:  a_q <= bus_i;
        OP_UP:    a_q <= b_i;
        default:  a_q <= a_q;
      endcase
    end
  end

  assign a_o = a_q;

  p_clear_a_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_CLEAR |=> a_q == '0);
  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_LOAD |=> a_q == $past(bus_i));
  p_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_UP |=> a_q == $past(b_i));
  p_a_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_HOLD || op_i == OP_DOWN || op_i == OP_SHIFT) |=> $stable(a_q));
endmodule

// File: rtl/dr_rank_b.sv
module dr_rank_b
  import dual_rank_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  op_e              op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] b_o,
  output logic             ser_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_q;
  logic [WIDTH-1:0] shifted;

  for (genvar i = 0; i < WIDTH; i++) begin : g_shift
    if (i == 0) begin : g_entry
      assign shifted[i] = ser_i;
    end else begin : g_link
      assign shifted[i] = b_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) b_q <= '0;
    else begin
      case (op_i)
        OP_CLEAR: b_q <= '0;
        OP_DOWN:  b_q <= a_i;
        OP_SHIFT: b_q <= shifted;
        default:  b_q <= b_q;
      endcase
    end
  end

  assign b_o   = b_q;
  assign ser_o = b_q[MSB];

  p_clear_b_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_CLEAR |=> b_q == '0);
  p_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_DOWN |=> b_q == $past(a_i));
  p_shift_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_SHIFT |=> b_q[0] == $past(ser_i) && ser_o == $past(b_q[MSB-1]));
  p_b_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_HOLD || op_i == OP_LOAD || op_i == OP_UP) |=> $stable(b_q));
endmodule

// File: rtl/dual_rank_shreg.sv
module dual_rank_shreg
  import dual_rank_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] bus_i,
  output logic [WIDTH-1:0] bus_o,
  output logic             bus_oe_o,
  input  logic             ser_i,
  output logic             ser_o,
  input  logic             load_ni,
  input  logic             drive_ni,
  input  logic             up_ni,
  input  logic             down_ni,
  input  logic             shift_ni
);
  op_e              op;
  logic [WIDTH-1:0] a_q;
  logic [WIDTH-1:0] b_q;

  dr_op_decode i_decode (
    .load_ni  (load_ni),
    .drive_ni (drive_ni),
    .up_ni    (up_ni),
    .down_ni  (down_ni),
    .shift_ni (shift_ni),
    .op_o     (op),
    .oe_o     (bus_oe_o)
  );

  dr_rank_a #(.WIDTH(WIDTH)) i_rank_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .bus_i  (bus_i),
    .b_i    (b_q),
    .a_o    (a_q)
  );

  dr_rank_b #(.WIDTH(WIDTH)) i_rank_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .a_i    (a_q),
    .ser_i  (ser_i),
    .b_o    (b_q),
    .ser_o  (ser_o)
  );

  assign bus_o = a_q;

  p_clear_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_ni && !down_ni) |=> bus_o == '0 && !ser_o);
  p_load_priority_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_ni && (up_ni || down_ni)) |=> bus_o == $past(bus_i));
  p_oe_rule_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (!drive_ni && load_ni));
endmodule

// File: tb/test_dual_rank_shreg.sv
`timescale 1ns/100ps
module test_dual_rank_shreg;
  localparam int W = 8;

  typedef struct {
    logic [W-1:0] a;
    logic         s;
    logic         oe;
    string        req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] bus_in = '0;
  logic [W-1:0] bus_out;
  logic oe, sin = 1'b0, sout;
  logic ld_n = 1'b1, dr_n = 1'b1, up_n = 1'b1, dn_n = 1'b1, sh_n = 1'b1;

  // cascade pair
  logic [W-1:0] c_bus_lo = '0, c_bus_hi = '0, c_out_lo, c_out_hi;
  logic c_oe_lo, c_oe_hi, c_link, c_sout;
  logic c_ld_n = 1'b1, c_up_n = 1'b1, c_dn_n = 1'b1, c_sh_n = 1'b1;

  int checks = 0, fails = 0;
  item_t q[$];
  logic [W-1:0] ma = '0, mb = '0;

  always #2.5 clk = ~clk;

  dual_rank_shreg #(.WIDTH(W)) i_dual_rank_shreg (
    .clk_i(clk), .rst_ni(rst_n), .bus_i(bus_in), .bus_o(bus_out), .bus_oe_o(oe),
    .ser_i(sin), .ser_o(sout), .load_ni(ld_n), .drive_ni(dr_n), .up_ni(up_n),
    .down_ni(dn_n), .shift_ni(sh_n));

  dual_rank_shreg #(.WIDTH(W)) i_lo (
    .clk_i(clk), .rst_ni(rst_n), .bus_i(c_bus_lo), .bus_o(c_out_lo), .bus_oe_o(c_oe_lo),
    .ser_i(1'b0), .ser_o(c_link), .load_ni(c_ld_n), .drive_ni(1'b1), .up_ni(c_up_n),
    .down_ni(c_dn_n), .shift_ni(c_sh_n));

  dual_rank_shreg #(.WIDTH(W)) i_hi (
    .clk_i(clk), .rst_ni(rst_n), .bus_i(c_bus_hi), .bus_o(c_out_hi), .bus_oe_o(c_oe_hi),
    .ser_i(c_link), .ser_o(c_sout), .load_ni(c_ld_n), .drive_ni(1'b1), .up_ni(c_up_n),
    .down_ni(c_dn_n), .shift_ni(c_sh_n));

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: applies one clock of controls and queues the expected result
  task automatic step(input logic l, d, u, dn, sh, input logic [W-1:0] b, input logic s, input string req);
    item_t it;
    @(negedge clk);
    ld_n = l; dr_n = d; up_n = u; dn_n = dn; sh_n = sh; bus_in = b; sin = s;
    if (!u && !dn) begin ma = '0; mb = '0; end
    else if (!l)   ma = b;
    else if (!u)   ma = mb;
    else if (!dn)  mb = ma;
    else if (!sh)  mb = {mb[W-2:0], s};
    it.a = ma; it.s = mb[W-1]; it.oe = !d && l; it.req = req;
    q.push_back(it);
  endtask

  // monitor
  initial forever begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(bus_out == it.a, {it.req, " bus_o"}, bus_out, it.a);
      chk(sout == it.s, {it.req, " ser_o"}, {{(W-1){1'b0}}, sout}, {{(W-1){1'b0}}, it.s});
      chk(oe == it.oe, {it.req, " bus_oe_o"}, {{(W-1){1'b0}}, oe}, {{(W-1){1'b0}}, it.oe});
    end
  end

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] pat;
    pat = 8'b1011_0010;
    ld_n = 1'b0; bus_in = 8'hFF; up_n = 1'b0; dn_n = 1'b1;
    #12;
    chk(bus_out == '0 && sout == 1'b0, "R1 reset", bus_out, '0);
    ld_n = 1'b1; up_n = 1'b1; bus_in = '0;
    @(negedge clk); rst_n = 1'b1;

    step(0, 1, 1, 1, 1, 8'h5A, 0, "R3 load");
    step(1, 1, 1, 0, 1, 8'h00, 0, "R5 down");
    step(0, 0, 1, 1, 1, 8'hC3, 0, "R9 load beats drive");
    step(1, 0, 1, 1, 1, 8'hEE, 0, "R8 hold while driving");
    step(1, 0, 0, 1, 1, 8'h00, 0, "R4 up");
    for (int i = W - 1; i >= 0; i--) step(1, 0, 1, 1, 0, 8'h00, pat[i], "R6 shift");
    step(1, 1, 0, 1, 1, 8'h00, 0, "R6 shift result via up");
    step(0, 1, 1, 1, 0, 8'h81, 1, "R7 load over shift");
    step(1, 1, 0, 1, 0, 8'h00, 0, "R7 up over shift");
    step(1, 1, 1, 0, 0, 8'h00, 1, "R7 down over shift");
    step(0, 1, 1, 1, 1, 8'h3C, 0, "R3 load new");
    step(1, 1, 0, 1, 1, 8'h00, 0, "R7 B held across load");
    step(0, 0, 0, 0, 0, 8'hFF, 1, "R2 clear beats all");
    step(1, 1, 0, 1, 1, 8'h00, 0, "R2 B cleared via up");
    step(0, 1, 1, 1, 1, 8'h77, 0, "R3 load");
    step(1, 1, 1, 0, 1, 8'h00, 0, "R5 down");
    step(1, 1, 1, 1, 1, 8'h00, 0, "R8 idle");
    repeat (3) @(negedge clk);

    // mid-run asynchronous reset
    #1 rst_n = 1'b0;
    #0.5;
    chk(bus_out == '0 && sout == 1'b0, "R1 async reset", bus_out, '0);
    ma = '0; mb = '0;
    @(negedge clk); rst_n = 1'b1;
    step(1, 1, 0, 1, 1, 8'h00, 0, "R1 B zero after reset");
    repeat (3) @(negedge clk);

    // cascade
    c_ld_n = 1'b0; c_bus_lo = 8'hA5; c_bus_hi = 8'h3C;
    @(negedge clk); c_ld_n = 1'b1; c_dn_n = 1'b0;
    @(negedge clk); c_dn_n = 1'b1; c_sh_n = 1'b0;
    repeat (W) @(negedge clk);
    c_sh_n = 1'b1; c_up_n = 1'b0;
    @(negedge clk); c_up_n = 1'b1;
    chk(c_out_hi == 8'hA5, "R10 upper holds lower word", c_out_hi, 8'hA5);
    chk(c_out_lo == 8'h00, "R10 lower filled with zeros", c_out_lo, 8'h00);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule